// File: doc/BRIEF.md
# Quad-SPI Boot Configuration Controller

This block brings a device out of reset by fetching its configuration bitstream from an external quad-SPI flash. In the first clock cycle after reset it reads three boot-mode strap pins, works out whether a flash boot was requested and at which clock rate, and from then on drives the shared pads as active-low chip selects. It issues a quad-read header (one command byte and a 24-bit start address, four bits per flash clock), waits a programmable number of dummy cycles, and then captures the returned data four bits at a time, assembling bytes and counting them against a length supplied at the port.

Two completion flags are provided. The first rises once the last byte of the bitstream has been captured and the flash select has been released. The second rises a fixed number of cycles later, marking entry into user mode. An active-low status line stays low while configuration runs and is released on success; a strap code that is not a flash boot produces a distinct release-then-low-pulse pattern instead. A flash reset request from elsewhere in the chip is held back until the flash transaction is closed.

Top module: `qspi_boot`

## Requirements
- R1: The strap pins `modeIn` are sampled exactly once, on the first rising clock edge after `rstN` deasserts; later changes on them have no effect on clock rate or on the boot.
- R2: Strap code 3'b001 selects fast boot with a flash clock of the system clock divided by 2; code 3'b011 selects normal boot with division by 4. Any other code starts no boot: `csOe` and `flashClk` stay low, `confDone` stays low, and `statusN` is high for one cycle, low for ERR_PULSE cycles, then high for good.
- R3: From the cycle after a valid sample, `csOe` is high for good; `csN[0]` is low exactly while the flash transaction runs and `csN[3:1]` are always high. During reset `csOe` is low and `csN` is all ones.
- R4: The header is eight nibbles on `flashDataOut`, most significant first: command byte 8'hEB, then the 24-bit `startAddr`. One nibble is presented per flash clock cycle, stable while `flashClk` is high, with `flashDataOe` high only during the header.
- R5: After the header, exactly `dummyCycles` flash clock cycles pass with no capture; from the next flash clock on, `flashDataIn` is captured on each rising edge of `flashClk`.
- R6: Captured nibbles are packed high nibble first; each completed byte appears on `byteOut` with `byteValid` high for one cycle.
- R7: `confDone` rises HALF system cycles after the `byteValid` of byte number `lengthIn` (HALF is half the flash clock divisor); at that point `csN` returns to all ones and no further byte is captured. `lengthIn` must be at least 1.
- R8: `initDone` rises exactly INIT_WAIT cycles after `confDone`, and both stay high afterwards.
- R9: `statusN` is low from reset until `confDone` rises on a successful boot, then high.
- R10: A pulse on `flashRstReq` while the flash is selected is deferred; `flashRstN` stays high until `csN[0]` is high again and then goes low for RST_LEN cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeIn | input | 3 | Boot-mode strap pins (bit 0 shares its pad with chip select 0) |
| csN | output | NUM_CS | Active-low flash chip selects |
| csOe | output | 1 | Output enable for the shared strap/select pads |
| flashClk | output | 1 | Flash serial clock |
| flashDataOut | output | 4 | Header nibble driven to the flash |
| flashDataOe | output | 1 | Output enable for the flash data pads |
| flashDataIn | input | 4 | Nibble returned by the flash |
| startAddr | input | ADDR_W | Flash start address of the bitstream |
| lengthIn | input | LEN_W | Bitstream length in bytes |
| dummyCycles | input | DUMMY_W | Dummy flash cycles between header and data |
| byteOut | output | 8 | Assembled bitstream byte |
| byteValid | output | 1 | One-cycle strobe for `byteOut` |
| statusN | output | 1 | Active-low configuration status |
| confDone | output | 1 | Whole bitstream received |
| initDone | output | 1 | User mode entered |
| flashRstReq | input | 1 | Request to reset the flash |
| flashRstN | output | 1 | Active-low flash reset |

## Verification
The bench changes the straps right after the sampling edge, swapping fast and normal or moving to an illegal code; a design that kept tracking the pins would change its flash clock period or abort mid-boot. It varies the dummy count from zero to ten, which a design with an off-by-one wait would expose as every captured byte shifted by one nibble, and it checks the header nibble order and the byte packing against a flash model, catching swapped nibbles or a reversed address. The exact cycle gap from the last byte to `confDone` and from `confDone` to `initDone` catches early or late completion, and a reset request fired mid-transfer catches a controller that pulls the flash reset while the select is still low.

// File: rtl/qspi_boot_pkg.sv
package qspi_boot_pkg;

  localparam logic [7:0] QREAD_CMD = 8'hEB;
  localparam logic [2:0] MODE_FAST = 3'b001;
  localparam logic [2:0] MODE_NORM = 3'b011;

  typedef enum logic [3:0] {
    ST_START,
    ST_HDR,
    ST_DUMMY,
    ST_DATA,
    ST_DONE,
    ST_USER,
    ST_ERR_REL,
    ST_ERR_LOW,
    ST_HALT
  } boot_state_e;

  // strobes from control to datapath, all decoded from control state
  typedef struct packed {
    logic clkRun;
    logic fastSel;
    logic loadHdr;
    logic hdrPhase;
    logic dataPhase;
  } dp_ctl_t;

endpackage

// File: rtl/qspi_boot_dp.sv
module qspi_boot_dp
  import qspi_boot_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int LEN_W    = 16,
  parameter int FAST_DIV = 2,
  parameter int NORM_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  lengthIn,
  input  logic [3:0]        flashDataIn,
  output logic              flashClk,
  output logic [3:0]        flashDataOut,
  output logic              flashDataOe,
  output logic              fallTick,
  output logic              countHit,
  output logic [7:0]        byteOut,
  output logic              byteValid
);

  localparam int SH_W    = 8 + ADDR_W;
  localparam int DIV_MAX = (FAST_DIV > NORM_DIV) ? FAST_DIV : NORM_DIV;
  localparam int DIV_W   = $clog2(DIV_MAX + 1);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] curDiv;
  logic [DIV_W-1:0] halfDiv;
  logic             riseTick;
  logic [SH_W-1:0]  shiftReg;
  logic [3:0]       hiNib;
  logic             lowNext;
  logic [LEN_W-1:0] byteCount;

  // flash clock generation: low for the first half of the divisor, high after
  assign curDiv   = ctl.fastSel ? DIV_W'(FAST_DIV) : DIV_W'(NORM_DIV);
  assign halfDiv  = curDiv >> 1;
  assign riseTick = ctl.clkRun && (divCnt == halfDiv - DIV_W'(1));
  assign fallTick = ctl.clkRun && (divCnt == curDiv - DIV_W'(1));
  assign flashClk = ctl.clkRun && (divCnt >= halfDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!ctl.clkRun || fallTick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // header shifter: command then address, one nibble per flash cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.loadHdr) begin
      shiftReg <= {QREAD_CMD, startAddr};
    end else if (ctl.hdrPhase && fallTick) begin
      shiftReg <= shiftReg << 4;
    end
  end

  assign flashDataOut = shiftReg[SH_W-1 -: 4];
  assign flashDataOe  = ctl.hdrPhase;

  // nibble capture and byte assembly, high nibble first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiNib     <= '0;
      lowNext   <= 1'b0;
      byteOut   <= '0;
      byteValid <= 1'b0;
      byteCount <= '0;
    end else begin
      byteValid <= 1'b0;
      if (ctl.loadHdr) begin
        lowNext   <= 1'b0;
        byteCount <= '0;
      end else if (ctl.dataPhase && riseTick) begin
        if (!lowNext) begin
          hiNib   <= flashDataIn;
          lowNext <= 1'b1;
        end else begin
          byteOut   <= {hiNib, flashDataIn};
          byteValid <= 1'b1;
          byteCount <= byteCount + LEN_W'(1);
          lowNext   <= 1'b0;
        end
      end
    end
  end

  assign countHit = (byteCount == lengthIn);

  // R4: header nibble held steady while the flash clock is high
  a_r4_hdr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.hdrPhase && flashClk) |-> $stable(flashDataOut))
    else $error("header nibble changed with flash clock high");

  // R6: no byte beyond the programmed length
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> (byteCount <= lengthIn))
    else $error("byte count overran length");

endmodule

// File: rtl/qspi_boot_ctrl.sv
module qspi_boot_ctrl
  import qspi_boot_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DUMMY_W   = 4,
  parameter int NUM_CS    = 4,
  parameter int INIT_WAIT = 8,
  parameter int ERR_PULSE = 4,
  parameter int RST_LEN   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         modeIn,
  input  logic [DUMMY_W-1:0] dummyCycles,
  input  logic               flashRstReq,
  input  logic               fallTick,
  input  logic               countHit,
  output dp_ctl_t            ctl,
  output logic [NUM_CS-1:0]  csN,
  output logic               csOe,
  output logic               statusN,
  output logic               confDone,
  output logic               initDone,
  output logic               flashRstN
);

  localparam int HDR_NIBS  = (8 + ADDR_W) / 4;
  localparam int DUMMY_MAX = 2 ** DUMMY_W;
  localparam int MAX_A     = (HDR_NIBS > DUMMY_MAX) ? HDR_NIBS : DUMMY_MAX;
  localparam int MAX_B     = (INIT_WAIT > ERR_PULSE) ? INIT_WAIT : ERR_PULSE;
  localparam int STEP_MAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int STEP_W    = $clog2(STEP_MAX + 1);
  localparam int RST_W     = $clog2(RST_LEN + 1);

  boot_state_e       state;
  logic [STEP_W-1:0] stepCnt;
  logic              fastReg;
  logic              modeValid;
  logic              inXfer;
  logic              busy;
  logic              rstPend;
  logic [RST_W-1:0]  rstCnt;

  assign modeValid = (modeIn == MODE_FAST) || (modeIn == MODE_NORM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_START;
      stepCnt <= '0;
      fastReg <= 1'b0;
    end else begin
      case (state)
        ST_START: begin
          fastReg <= (modeIn == MODE_FAST);
          stepCnt <= '0;
          state   <= modeValid ? ST_HDR : ST_ERR_REL;
        end
        ST_HDR: begin
          if (fallTick) begin
            if (stepCnt == STEP_W'(HDR_NIBS - 1)) begin
              stepCnt <= '0;
              state   <= (dummyCycles == '0) ? ST_DATA : ST_DUMMY;
            end else begin
              stepCnt <= stepCnt + STEP_W'(1);
            end
          end
        end
        ST_DUMMY: begin
          if (fallTick) begin
            if (stepCnt == STEP_W'(dummyCycles) - STEP_W'(1)) begin
              stepCnt <= '0;
              state   <= ST_DATA;
            end else begin
              stepCnt <= stepCnt + STEP_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (fallTick && countHit) begin
            stepCnt <= '0;
            state   <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (stepCnt == STEP_W'(INIT_WAIT - 1)) begin
            stepCnt <= '0;
            state   <= ST_USER;
          end else begin
            stepCnt <= stepCnt + STEP_W'(1);
          end
        end
        ST_ERR_REL: begin
          stepCnt <= '0;
          state   <= ST_ERR_LOW;
        end
        ST_ERR_LOW: begin
          if (stepCnt == STEP_W'(ERR_PULSE - 1)) begin
            stepCnt <= '0;
            state   <= ST_HALT;
          end else begin
            stepCnt <= stepCnt + STEP_W'(1);
          end
        end
        default: state <= state;
      endcase
    end
  end

  assign inXfer   = (state == ST_HDR) || (state == ST_DUMMY) || (state == ST_DATA);
  assign csOe     = inXfer || (state == ST_DONE) || (state == ST_USER);
  assign statusN  = (state == ST_DONE) || (state == ST_USER) ||
                    (state == ST_ERR_REL) || (state == ST_HALT);
  assign confDone = (state == ST_DONE) || (state == ST_USER);
  assign initDone = (state == ST_USER);

  // select 0 follows the transaction, the rest stay deasserted
  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
    if (gi == 0) begin : g_primary
      assign csN[gi] = !inXfer;
    end else begin : g_spare
      assign csN[gi] = 1'b1;
    end
  end

  assign ctl.clkRun    = inXfer;
  assign ctl.fastSel   = fastReg;
  assign ctl.loadHdr   = (state == ST_START) && modeValid;
  assign ctl.hdrPhase  = (state == ST_HDR);
  assign ctl.dataPhase = (state == ST_DATA);

  // flash reset is held back until the transaction has closed
  assign busy = (state == ST_START) || inXfer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstPend <= 1'b0;
      rstCnt  <= '0;
    end else if (rstCnt != '0) begin
      rstCnt <= rstCnt - RST_W'(1);
      if (flashRstReq) rstPend <= 1'b1;
    end else if ((rstPend || flashRstReq) && !busy) begin
      rstCnt  <= RST_W'(RST_LEN);
      rstPend <= 1'b0;
    end else if (flashRstReq) begin
      rstPend <= 1'b1;
    end
  end

  assign flashRstN = (rstCnt == '0);

  // R1: decoded mode frozen once the start state has passed
  a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_START) |=> $stable(fastReg))
    else $error("mode changed after sampling");

  // R3: once the pads turn into selects they stay outputs
  a_r3_oe_sticky: assert property (@(posedge clk) disable iff (!rstN)
    csOe |=> csOe)
    else $error("select output enable dropped");

  // R7: completion only after the byte count matched
  a_r7_done_on_count: assert property (@(posedge clk) disable iff (!rstN)
    $rose(confDone) |-> $past(countHit))
    else $error("done raised before full length");

  // R8: user mode never without bitstream complete
  a_r8_init_after_conf: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> confDone)
    else $error("init done without conf done");

  // R10: flash never reset while selected
  a_r10_no_rst_selected: assert property (@(posedge clk) disable iff (!rstN)
    !flashRstN |-> csN[0])
    else $error("flash reset during transaction");

endmodule

// File: rtl/qspi_boot.sv
module qspi_boot
  import qspi_boot_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 16,
  parameter int DUMMY_W   = 4,
  parameter int NUM_CS    = 4,
  parameter int FAST_DIV  = 2,
  parameter int NORM_DIV  = 4,
  parameter int INIT_WAIT = 8,
  parameter int ERR_PULSE = 4,
  parameter int RST_LEN   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         modeIn,
  output logic [NUM_CS-1:0]  csN,
  output logic               csOe,
  output logic               flashClk,
  output logic [3:0]         flashDataOut,
  output logic               flashDataOe,
  input  logic [3:0]         flashDataIn,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic [LEN_W-1:0]   lengthIn,
  input  logic [DUMMY_W-1:0] dummyCycles,
  output logic [7:0]         byteOut,
  output logic               byteValid,
  output logic               statusN,
  output logic               confDone,
  output logic               initDone,
  input  logic               flashRstReq,
  output logic               flashRstN
);

  dp_ctl_t ctlBus;
  logic    fallTick;
  logic    countHit;

  qspi_boot_ctrl #(
    .ADDR_W(ADDR_W), .DUMMY_W(DUMMY_W), .NUM_CS(NUM_CS),
    .INIT_WAIT(INIT_WAIT), .ERR_PULSE(ERR_PULSE), .RST_LEN(RST_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .dummyCycles(dummyCycles),
    .flashRstReq(flashRstReq), .fallTick(fallTick), .countHit(countHit),
    .ctl(ctlBus), .csN(csN), .csOe(csOe), .statusN(statusN),
    .confDone(confDone), .initDone(initDone), .flashRstN(flashRstN)
  );

  qspi_boot_dp #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FAST_DIV(FAST_DIV), .NORM_DIV(NORM_DIV)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .startAddr(startAddr),
    .lengthIn(lengthIn), .flashDataIn(flashDataIn), .flashClk(flashClk),
    .flashDataOut(flashDataOut), .flashDataOe(flashDataOe),
    .fallTick(fallTick), .countHit(countHit), .byteOut(byteOut),
    .byteValid(byteValid)
  );

endmodule

// File: tb/qspi_boot_bench.sv
`timescale 1ns/1ps
module qspi_boot_bench;

  localparam int INIT_WAIT = 8;
  localparam int ERR_PULSE = 4;
  localparam int RST_LEN   = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  modeIn = 3'b001;
  logic [3:0]  csN;
  logic        csOe;
  logic        flashClk;
  logic [3:0]  flashDataOut;
  logic        flashDataOe;
  logic [3:0]  flashDataIn = 4'h0;
  logic [23:0] startAddr = '0;
  logic [15:0] lengthIn = 16'd1;
  logic [3:0]  dummyCycles = '0;
  logic [7:0]  byteOut;
  logic        byteValid;
  logic        statusN;
  logic        confDone;
  logic        initDone;
  logic        flashRstReq = 1'b0;
  logic        flashRstN;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // flash model state
  int        edgeCnt = 0;
  int        curDummy = 0;
  logic [3:0] sentNib [8];
  realtime   lastRise = 0;
  realtime   flashPeriod = 0;
  logic [7:0] rxBytes [64];
  int        rxCnt = 0;

  always #4 clk = ~clk;

  qspi_boot #(.INIT_WAIT(INIT_WAIT), .ERR_PULSE(ERR_PULSE), .RST_LEN(RST_LEN))
  u_qspi_boot (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .csN(csN), .csOe(csOe),
    .flashClk(flashClk), .flashDataOut(flashDataOut), .flashDataOe(flashDataOe),
    .flashDataIn(flashDataIn), .startAddr(startAddr), .lengthIn(lengthIn),
    .dummyCycles(dummyCycles), .byteOut(byteOut), .byteValid(byteValid),
    .statusN(statusN), .confDone(confDone), .initDone(initDone),
    .flashRstReq(flashRstReq), .flashRstN(flashRstN)
  );

  function automatic logic [7:0] byteAt(input int j);
    return 8'((j * 29 + 60) ^ (j * 7));
  endfunction

  // flash model: record header on rising edges
  initial begin
    forever begin
      @(posedge flashClk);
      if (!csN[0]) begin
        if (edgeCnt < 8) sentNib[edgeCnt] = flashDataOut;
        if (lastRise != 0) flashPeriod = $realtime - lastRise;
        lastRise = $realtime;
        edgeCnt++;
      end
    end
  end

  // flash model: present the next data nibble after each falling edge
  initial begin
    forever begin
      @(negedge flashClk);
      begin
        int d;
        logic [7:0] b;
        d = edgeCnt - 8 - curDummy;
        if (d >= 0) begin
          b = byteAt(d / 2);
          flashDataIn = (d % 2 == 0) ? b[7:4] : b[3:0];
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applyReset(input logic [2:0] mode, input int dummy, input int len,
                            input logic [23:0] addr);
    rstN = 1'b0;
    flashRstReq = 1'b0;
    modeIn = mode;
    dummyCycles = 4'(dummy);
    lengthIn = 16'(len);
    startAddr = addr;
    curDummy = dummy;
    edgeCnt = 0;
    rxCnt = 0;
    lastRise = 0;
    flashPeriod = 0;
    flashDataIn = 4'h0;
    repeat (3) @(negedge clk);
  endtask

  task automatic runBoot(input logic [2:0] mode, input int dummy, input int len,
                         input logic [23:0] addr, input logic [2:0] newMode,
                         input bit rstDuring);
    int cyc, lastByteCyc, doneCyc, badStatus, rstViol, upperViol, half, errs, firstBad;
    int initCyc, lowCnt, confDrop;
    bit reqSent;
    logic [31:0] hdr;
    applyReset(mode, dummy, len, addr);
    // reset state
    check(statusN == 1'b0, "R9 statusN in reset", statusN, 0);
    check(csOe == 1'b0 && csN == 4'hF, "R3 pads idle in reset", {csOe, csN}, 15);
    check(confDone == 1'b0 && initDone == 1'b0, "R7 flags clear in reset",
          {confDone, initDone}, 0);
    check(flashRstN == 1'b1 && flashClk == 1'b0, "R10 flash idle in reset",
          {flashRstN, flashClk}, 2);
    rstN = 1'b1;
    @(negedge clk);
    check(csOe == 1'b1 && csN == 4'b1110, "R3 select asserted", {csOe, csN}, 30);
    modeIn = newMode;
    half = (mode == 3'b001) ? 1 : 2;
    cyc = 0; lastByteCyc = -1; doneCyc = -1;
    badStatus = 0; rstViol = 0; upperViol = 0; reqSent = 1'b0;
    while (doneCyc < 0 && cyc < 5000) begin
      if (byteValid) begin
        if (rxCnt < 64) rxBytes[rxCnt] = byteOut;
        rxCnt++;
        lastByteCyc = cyc;
      end
      if (confDone) doneCyc = cyc;
      else if (statusN) badStatus++;
      if (!csN[0] && !flashRstN) rstViol++;
      if (csN[3:1] != 3'b111) upperViol++;
      if (rstDuring && rxCnt == 2 && !reqSent) begin
        flashRstReq = 1'b1;
        reqSent = 1'b1;
      end else begin
        flashRstReq = 1'b0;
      end
      if (doneCyc < 0) begin
        @(negedge clk);
        cyc++;
      end
    end
    check(doneCyc >= 0, "R7 confDone reached", doneCyc, 1);
    check(rxCnt == len, "R7 byte count", rxCnt, len);
    errs = 0; firstBad = -1;
    for (int j = 0; j < len && j < rxCnt; j++) begin
      if (rxBytes[j] !== byteAt(j)) begin
        errs++;
        if (firstBad < 0) firstBad = j;
      end
    end
    if (firstBad >= 0)
      check(1'b0, "R5 R6 captured byte", rxBytes[firstBad], byteAt(firstBad));
    else
      check(1'b1, "R5 R6 captured bytes", 0, 0);
    hdr = {8'hEB, addr};
    errs = 0; firstBad = -1;
    for (int k = 0; k < 8; k++) begin
      if (sentNib[k] !== hdr[31 - 4*k -: 4]) begin
        errs++;
        if (firstBad < 0) firstBad = k;
      end
    end
    if (firstBad >= 0)
      check(1'b0, "R4 header nibble", sentNib[firstBad], hdr[31 - 4*firstBad -: 4]);
    else
      check(1'b1, "R4 header nibbles", 0, 0);
    check(int'(flashPeriod) == 8 * 2 * half,
          (newMode != mode) ? "R1 R2 flash period after strap change" : "R2 flash period",
          int'(flashPeriod), 8 * 2 * half);
    check(doneCyc - lastByteCyc == half, "R7 done after last byte",
          doneCyc - lastByteCyc, half);
    check(badStatus == 0 && statusN == 1'b1, "R9 status low until done",
          badStatus, 0);
    check(csN == 4'hF && csOe == 1'b1 && upperViol == 0, "R3 select released",
          {upperViol, csOe, csN}, 31);
    initCyc = -1; lowCnt = 0; confDrop = 0;
    for (int k = 1; k <= INIT_WAIT + RST_LEN + 6; k++) begin
      @(negedge clk);
      if (initDone && initCyc < 0) initCyc = k;
      if (!flashRstN) lowCnt++;
      if (!confDone) confDrop++;
    end
    check(initCyc == INIT_WAIT, "R8 initDone delay", initCyc, INIT_WAIT);
    check(confDrop == 0 && initDone == 1'b1, "R8 flags stay high", confDrop, 0);
    check(rstViol == 0, "R10 no reset while selected", rstViol, 0);
    check(lowCnt == (rstDuring ? RST_LEN : 0), "R10 deferred reset length",
          lowCnt, rstDuring ? RST_LEN : 0);
  endtask

  task automatic runInvalid(input logic [2:0] code);
    int errs, oeSeen, clkSeen, doneSeen;
    logic expS;
    applyReset(code, 0, 4, 24'h000100);
    rstN = 1'b1;
    errs = 0; oeSeen = 0; clkSeen = 0; doneSeen = 0;
    for (int k = 1; k <= ERR_PULSE + 20; k++) begin
      @(negedge clk);
      if (k == 3) modeIn = 3'b001;
      expS = (k == 1 || k > ERR_PULSE + 1);
      if (statusN !== expS) errs++;
      if (csOe) oeSeen++;
      if (flashClk) clkSeen++;
      if (confDone) doneSeen++;
    end
    check(errs == 0, "R2 invalid code status pattern", errs, 0);
    check(oeSeen == 0 && clkSeen == 0, "R2 invalid code leaves flash idle",
          oeSeen + clkSeen, 0);
    check(doneSeen == 0 && edgeCnt == 0, "R1 R2 late valid strap ignored",
          doneSeen + edgeCnt, 0);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    runBoot(3'b001, 0, 4, 24'h123456, 3'b001, 1'b0);
    runBoot(3'b011, 6, 6, 24'hA5F00C, 3'b001, 1'b1);
    runBoot(3'b001, 10, 3, 24'hFFFFFF, 3'b111, 1'b0);
    runBoot(3'b011, 1, 5, 24'h0C0A01, 3'b011, 1'b0);
    runInvalid(3'b000);
    runInvalid(3'b111);
    runInvalid(3'b010);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule